// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that writes one 32-bit dword per cycle and a bank of internal registers that may be 128 bits wide. Wide registers cannot take a single dword write. Instead, the block gathers dwords in a holding buffer and issues one atomic commit, carrying an aligned address and 128 bits of data, once the target is complete. The buffer keeps a valid bit for each dword and an address tag. Memory words of 64 bits go through the same buffer and complete with two dwords. Ordinary 32-bit registers pass straight through to the commit port.

The register space is split into pages of 0x2000 bytes. Each page holds two descriptor-pointer registers, which are 128 bits wide and write-only. A write to the top dword of one of them commits at once, without waiting for the lower dwords. In page 0 there is also a timer-command register, and a write to it empties the holding buffer. The host is expected to serialise its partial writes to different wide targets, because interleaving them loses data.

Top module: `wide_wr_gather`

## Requirements
- R1: After reset `cm_vld` is 0 and the holding buffer is empty.
- R2: A write to the register space (address bit AW-1 = 0) at an in-page offset below 0x800 commits in the next cycle. It carries `cm_size` = 0, the address rounded down to 4 bytes and the data zero-extended to 128 bits. It leaves any held dwords untouched.
- R3: A register-space write at an in-page offset of 0x800 or above, other than a descriptor pointer, is a dword of a normal 128-bit register. Dword i = address bits [3:2] fills data bits 32i+31:32i. The commit (`cm_size` = 2, address rounded down to 16 bytes) comes in the cycle after the fourth distinct dword arrives, whatever the order. There is no commit before that.
- R4: A write with address bit AW-1 = 1 is a dword of a 64-bit memory word, selected by address bit 2. The commit (`cm_size` = 1, address rounded down to 8 bytes, bits 127:64 zero) comes in the cycle after both dwords are present.
- R5: A normal-wide or memory-word write whose aligned address differs from the held tag starts a new collection. The old dwords are dropped without any commit.
- R6: In every page, the descriptor pointers sit at in-page offsets 0x830 and 0xA10. A write to a descriptor's top dword (address bits [3:2] = 3) commits in the next cycle with `cm_size` = 2. If the buffer holds dwords 0, 1 and 2 for that same register, the commit carries the full value and the buffer empties.
- R7: If those three lower dwords are not all held for that register, a descriptor top-dword commit carries zero in bits 95:0. A buffer that holds a different register keeps its contents.
- R8: A write to a lower dword of a descriptor pointer is discarded while the buffer holds dwords of a different register. The buffer keeps its contents.
- R9: A write to offset 0x420 in page 0 commits as a plain register and empties the buffer. The same offset in any other page leaves the buffer alone.
- R10: Writing a dword that is already held replaces it, so the later value reaches the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | AW | Byte address of the dword |
| wr_data | input | 32 | Dword value |
| cm_vld | output | 1 | Single-cycle commit pulse |
| cm_size | output | 2 | Commit width: 0 = 32-bit, 1 = 64-bit, 2 = 128-bit |
| cm_addr | output | AW | Aligned commit address |
| cm_data | output | 128 | Commit data |

## Verification
A wrong valid bit or tag does not show at the port straight away. It stays hidden until the write that should complete a register. At that point it appears either as a missing commit pulse, a premature commit pulse, or a commit whose dword fields hold a stale or zero value. Because of this, every collection in the bench is run through to its completing write, and the commit cycle and data are compared there. Each drop, replace and clear case is also followed by a collection whose outcome depends on what the buffer should still hold.

// File: rtl/wide_wr_gather.sv
module wide_wr_gather #(
  parameter int AW         = 20,
  parameter int PAGE_BITS  = 13,
  parameter int WIDE_BASE  = 'h800,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'hA10,
  parameter int TIMER_OFF  = 'h420
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  output logic           cm_vld,
  output logic [1:0]     cm_size,
  output logic [AW-1:0]  cm_addr,
  output logic [127:0]   cm_data
);
  localparam int PB = PAGE_BITS;
  localparam logic [PB-1:0] DA = PB'(DESC_A);
  localparam logic [PB-1:0] DB = PB'(DESC_B);
  localparam logic [PB-1:0] TO = PB'(TIMER_OFF);
  localparam logic [PB-1:0] WB = PB'(WIDE_BASE);

  logic [3:0][31:0] buf_q;
  logic [3:0]       vld_q;
  logic [AW-1:0]    tag_q;

  wire          in_mem  = wr_addr[AW-1];
  wire [PB-1:0] off     = wr_addr[PB-1:0];
  wire          page0   = (wr_addr[AW-2:PB] == '0);
  wire          is_desc = !in_mem && (off[PB-1:4] == DA[PB-1:4] || off[PB-1:4] == DB[PB-1:4]);
  wire          is_wide = !in_mem && (off >= WB);
  wire          is_tmr  = !in_mem && page0 && (off[PB-1:2] == TO[PB-1:2]);
  wire [AW-1:0] base    = in_mem ? {wr_addr[AW-1:3], 3'b0} : {wr_addr[AW-1:4], 4'b0};
  wire [1:0]    idx     = in_mem ? {1'b0, wr_addr[2]} : wr_addr[3:2];
  wire          held    = |vld_q;
  wire          hit     = held && (tag_q == base);
  wire [3:0]    sel     = 4'b0001 << idx;
  wire [3:0]    nv      = (hit ? vld_q : 4'b0) | sel;
  wire [3:0]    need    = in_mem ? 4'b0011 : 4'b1111;
  wire          full    = ((nv & need) == need);

  logic [127:0] merged;
  always_comb begin
    for (int i = 0; i < 4; i++)
      merged[32*i +: 32] = sel[i] ? wr_data : ((hit && vld_q[i]) ? buf_q[i] : 32'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      tag_q   <= '0;
      buf_q   <= '0;
      cm_vld  <= 1'b0;
      cm_size <= 2'd0;
      cm_addr <= '0;
      cm_data <= '0;
    end else begin
      cm_vld <= 1'b0;
      if (wr_en) begin
        if (!in_mem && !is_wide) begin
          cm_vld  <= 1'b1;
          cm_size <= 2'd0;
          cm_addr <= {wr_addr[AW-1:2], 2'b0};
          cm_data <= {96'h0, wr_data};
          if (is_tmr) vld_q <= '0;
        end else if (is_desc) begin
          if (idx == 2'd3) begin
            cm_vld  <= 1'b1;
            cm_size <= 2'd2;
            cm_addr <= base;
            cm_data <= {wr_data, (hit && vld_q[2:0] == 3'b111) ? merged[95:0] : 96'h0};
            if (hit) vld_q <= '0;
          end else if (!held || hit) begin
            buf_q[idx] <= wr_data;
            vld_q      <= nv;
            tag_q      <= base;
          end
        end else if (full) begin
          cm_vld  <= 1'b1;
          cm_size <= in_mem ? 2'd1 : 2'd2;
          cm_addr <= base;
          cm_data <= merged;
          vld_q   <= '0;
        end else begin
          buf_q[idx] <= wr_data;
          vld_q      <= nv;
          tag_q      <= base;
        end
      end
    end
  end

  // R2
  commit_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |-> $past(wr_en));
  // R3
  early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (is_wide || in_mem) && !is_desc && !full) |=> !cm_vld);
  // R6
  desc_top_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_desc && idx == 2'd3) |=> (cm_vld && cm_size == 2'd2));
  // R8
  desc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_desc && idx != 2'd3 && held && !hit) |=> ($stable(vld_q) && $stable(tag_q) && !cm_vld));
  // R9
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_tmr) |=> (vld_q == 4'b0 && cm_vld));
  // R4
  mem_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && tag_q[AW-1]) |-> (vld_q[3:2] == 2'b00));
endmodule

// File: tb/wide_wr_gather_tb_top.sv
`timescale 1ns/1ps
module wide_wr_gather_tb_top;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cm_vld;
  logic [1:0] cm_size;
  logic [AW-1:0] cm_addr;
  logic [127:0] cm_data;
  int n_chk = 0, n_bad = 0;

  wide_wr_gather #(.AW(AW)) dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cm_vld(cm_vld), .cm_size(cm_size), .cm_addr(cm_addr), .cm_data(cm_data));

  always #5 clk = ~clk;

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic expect_cm(input string req, input logic [1:0] s, input logic [AW-1:0] a, input logic [127:0] d);
    n_chk++;
    if (!(cm_vld === 1'b1 && cm_size === s && cm_addr === a && cm_data === d)) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b size=%0d addr=%h data=%h, exp vld=1 size=%0d addr=%h data=%h",
               req, cm_vld, cm_size, cm_addr, cm_data, s, a, d);
    end
  endtask

  task automatic expect_none(input string req);
    n_chk++;
    if (cm_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b, exp vld=0", req, cm_vld);
    end
  endtask

  localparam logic [AW-1:0] WREG = 20'h04900;
  localparam logic [AW-1:0] WRG2 = 20'h04A00;

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    expect_none("R1");

    // R2 plain register sweep across pages
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 'h800; o += 'h104) begin
        logic [AW-1:0] a = AW'(p * 'h2000 + o);
        logic [31:0] d = 32'h1000_0000 + 32'(p * 'h1000 + o);
        if (!(p == 0 && o[12:2] == 'h420 >> 2)) begin
          wr(a, d);
          expect_cm("R2", 2'd0, {a[AW-1:2], 2'b0}, {96'h0, d});
        end
      end

    // R3 all 24 dword orders
    for (int a0 = 0; a0 < 4; a0++)
      for (int a1 = 0; a1 < 4; a1++)
        for (int a2 = 0; a2 < 4; a2++)
          for (int a3 = 0; a3 < 4; a3++)
            if (((1 << a0) | (1 << a1) | (1 << a2) | (1 << a3)) == 15) begin
              int ord[4];
              logic [127:0] ex;
              int tag = a0 * 64 + a1 * 16 + a2 * 4 + a3;
              ord[0] = a0; ord[1] = a1; ord[2] = a2; ord[3] = a3;
              for (int k = 0; k < 4; k++) ex[32*k +: 32] = 32'hC000_0000 + 32'(tag * 16 + k);
              for (int k = 0; k < 4; k++) begin
                wr(WREG + AW'(ord[k] * 4), ex[32*ord[k] +: 32]);
                if (k < 3) expect_none("R3");
                else expect_cm("R3", 2'd2, WREG, ex);
              end
            end

    // R4 memory words, both orders
    for (int w = 0; w < 8; w++) begin
      logic [AW-1:0] b = 20'h80000 + AW'(w * 8);
      logic [31:0] lo = 32'h5000_0000 + 32'(w);
      logic [31:0] hi = 32'h6000_0000 + 32'(w);
      if (w[0]) begin wr(b + 4, hi); expect_none("R4"); wr(b, lo); end
      else begin wr(b, lo); expect_none("R4"); wr(b + 4, hi); end
      expect_cm("R4", 2'd1, b, {64'h0, hi, lo});
    end

    // R5 replacement by a different wide register
    wr(WREG + 0, 32'hAAAA_0000); wr(WREG + 4, 32'hAAAA_0001);
    wr(WRG2 + 8, 32'hBBBB_0002); expect_none("R5");
    wr(WRG2 + 0, 32'hBBBB_0000); wr(WRG2 + 4, 32'hBBBB_0001); expect_none("R5");
    wr(WRG2 + 12, 32'hBBBB_0003);
    expect_cm("R5", 2'd2, WRG2, {32'hBBBB_0003, 32'hBBBB_0002, 32'hBBBB_0001, 32'hBBBB_0000});
    wr(WREG + 0, 32'hAAAA_0000); wr(WREG + 8, 32'hAAAA_0002);
    wr(20'h80010, 32'h7000_0000); // memory word replaces the wide partial
    wr(WREG + 4, 32'hAAAA_0001); wr(WREG + 12, 32'hAAAA_0003);
    expect_none("R5");
    wr(WREG + 0, 32'hAAAA_1000); wr(WREG + 8, 32'hAAAA_1002);
    expect_cm("R5", 2'd2, WREG, {32'hAAAA_0003, 32'hAAAA_1002, 32'hAAAA_0001, 32'hAAAA_1000});

    // R6 / R7 descriptor subsets
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 8; s++) begin
          logic [AW-1:0] b = AW'((p ? 5 : 0) * 'h2000 + (r ? 'hA10 : 'h830));
          logic [127:0] ex;
          for (int k = 0; k < 4; k++) ex[32*k +: 32] = 32'hD000_0000 + 32'(p * 4096 + r * 256 + s * 16 + k);
          for (int k = 0; k < 3; k++)
            if (s[k]) begin wr(b + AW'(k * 4), ex[32*k +: 32]); expect_none("R6"); end
          wr(b + 12, ex[127:96]);
          if (s == 7) expect_cm("R6", 2'd2, b, ex);
          else expect_cm("R7", 2'd2, b, {ex[127:96], 96'h0});
        end

    // R7 other register held, top dword commits with zeros and holding kept
    wr(WREG + 0, 32'hE000_0000);
    wr(20'h0083C, 32'hE0E0_0003);
    expect_cm("R7", 2'd2, 20'h00830, {32'hE0E0_0003, 96'h0});
    wr(WREG + 4, 32'hE000_0001); wr(WREG + 8, 32'hE000_0002); wr(WREG + 12, 32'hE000_0003);
    expect_cm("R7", 2'd2, WREG, {32'hE000_0003, 32'hE000_0002, 32'hE000_0001, 32'hE000_0000});

    // R8 stray descriptor lower dword dropped
    wr(WREG + 0, 32'hF000_0000);
    wr(20'h00834, 32'hF0F0_0001); expect_none("R8");
    wr(WREG + 4, 32'hF000_0001); wr(WREG + 8, 32'hF000_0002); wr(WREG + 12, 32'hF000_0003);
    expect_cm("R8", 2'd2, WREG, {32'hF000_0003, 32'hF000_0002, 32'hF000_0001, 32'hF000_0000});
    wr(20'h00830, 32'hF0F0_0000); wr(20'h0083C, 32'hF0F0_0003);
    expect_cm("R8", 2'd2, 20'h00830, {32'hF0F0_0003, 96'h0});

    // R9 timer clears in page 0 only
    wr(WREG + 0, 32'h9000_0000); wr(WREG + 4, 32'h9000_0001);
    wr(20'h00420, 32'h0000_1234);
    expect_cm("R9", 2'd0, 20'h00420, {96'h0, 32'h0000_1234});
    wr(WREG + 8, 32'h9000_0002); wr(WREG + 12, 32'h9000_0003); expect_none("R9");
    wr(WREG + 0, 32'h9000_0010); wr(WREG + 4, 32'h9000_0011);
    expect_cm("R9", 2'd2, WREG, {32'h9000_0003, 32'h9000_0002, 32'h9000_0011, 32'h9000_0010});
    wr(WREG + 0, 32'h9100_0000);
    wr(20'h06420, 32'h0000_5678);
    expect_cm("R9", 2'd0, 20'h06420, {96'h0, 32'h0000_5678});
    wr(WREG + 4, 32'h9100_0001); wr(WREG + 8, 32'h9100_0002); wr(WREG + 12, 32'h9100_0003);
    expect_cm("R9", 2'd2, WREG, {32'h9100_0003, 32'h9100_0002, 32'h9100_0001, 32'h9100_0000});

    // R10 overwrite of a held dword
    wr(WREG + 4, 32'h1111_1111); wr(WREG + 4, 32'h2222_2222);
    wr(WREG + 0, 32'h3333_0000); wr(WREG + 8, 32'h3333_0002); expect_none("R10");
    wr(WREG + 12, 32'h3333_0003);
    expect_cm("R10", 2'd2, WREG, {32'h3333_0003, 32'h3333_0002, 32'h2222_2222, 32'h3333_0000});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule